// File: doc/BRIEF.md
# Indirect Network Controller Register Interface

This block is the register front end that a host processor sees on an Ethernet controller. Two 16-bit word ports are exposed. One port holds a small register pointer. The other port is a data window onto whichever of four control/status registers that pointer selects. Reads are combinational from the stored state. Writes take effect on the next rising clock edge.

Register 0 is the main control word. It combines several kinds of bit: start, stop and initialise commands; status bits that the host clears by writing a one; summary bits that hardware recomputes; and an interrupt enable that follows the written value. Registers 1 and 2 hold the low and high halves of a 32-bit initialisation-block address, which goes to the DMA side. Register 3 is stored and read back but drives nothing. The receive and transmit engines report completed work through single-cycle strobes. The block combines those events with the enable bit to drive a level interrupt line.

Top module: `netctl_regif`

## Requirements
- R1: After synchronous active-low reset, control word = 0x0004 (only the stop bit, bit 2), pointer = 0, registers 1 to 3 = 0, and the interrupt output is low.
- R2: A write to the pointer port (host_sel = 1) loads the pointer only when the value is below 4. Values of 4 or more leave it unchanged. Reading the pointer port returns the pointer zero-extended to 16 bits.
- R3: The data port (host_sel = 0) reads and writes only the register the pointer selects. A data write to registers 1 to 3 leaves the control word unchanged.
- R4: A control-word write with bit 2 set makes the control word exactly 0x0004, whatever else is in the written value and whatever strobes arrive in that cycle.
- R5: Otherwise, writing a one to any of control bits 14..8 clears that bit. Writing a zero leaves it unchanged.
- R6: On each control-word write without stop, bit 15 is recomputed as the OR of bits 14, 13, 12 and 8, and bit 7 as the OR of bits 14..8. Both are taken after clearing and before command bits are applied.
- R7: On a control-word write without stop, bit 6 (interrupt enable) takes the written bit 6.
- R8: In a control-word write without stop, written bit 0 sets bits 0 and 8 and clears bit 2. Otherwise, written bit 1 sets bits 1, 5 and 4 and clears bit 2. Bit 0 has priority over bit 1.
- R9: init_ptr equals {register 2, register 1}. Both registers read back the last written value.
- R10: A receive strobe sets bit 10, and a transmit strobe sets bit 9. Either strobe also sets bit 7 in the same cycle. A host clear of the same bit in that cycle loses to the strobe.
- R11: irq is high exactly when control bits 7 and 6 are both set.
- R12: Register 3 reads back its last written value, and writing it changes neither the control word nor irq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_sel | input | 1 | Word port select: 0 data window, 1 pointer |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data of the selected port |
| rx_done | input | 1 | Receive completion strobe |
| tx_done | input | 1 | Transmit completion strobe |
| init_ptr | output | 32 | Initialisation-block address |
| irq | output | 1 | Level interrupt request |

## Verification
The control word is driven through a sequence of write values. The sequence covers start alone, init with enable, a plain enable write that exposes the delayed summary recomputation, clears paired with a concurrent receive strobe, a strobe with no host write, a clear that collides with a transmit strobe, and a stop that carries other bits. Each step separates the ordering of the four bit classes: clear before summary, summary before command, hardware set over host clear, and stop over all. Directed cases then cover pointer values at and above the limit, the split address halves, the inert spare register, init and start written together, and reset in the middle of operation.

// File: rtl/netctl_pkg.sv
// Package: shared bit positions and register indices for the network
// controller register interface. Assumes a 16-bit control word.
package netctl_pkg;
    localparam int CW_ERR   = 15;
    localparam int CW_RINT  = 10;
    localparam int CW_TINT  = 9;
    localparam int CW_IDON  = 8;
    localparam int CW_INTR  = 7;
    localparam int CW_IEN   = 6;
    localparam int CW_RXON  = 5;
    localparam int CW_TXON  = 4;
    localparam int CW_STOP  = 2;
    localparam int CW_START = 1;
    localparam int CW_INIT  = 0;
    localparam int CW_CLR_LO = 8;
    localparam int CW_CLR_HI = 14;
    localparam logic [15:0] CW_RESET = 16'h0004;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_ADRLO = 2'd1,
        REG_ADRHI = 2'd2,
        REG_SPARE = 2'd3
    } reg_idx_e;
endpackage

// File: rtl/netctl_ptr.sv
// Module: register pointer. Loads the host value when it is below
// NUM_REGS and otherwise holds. Assumes a single-cycle write strobe.
module netctl_ptr #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 4,
    localparam int PTR_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [PTR_W-1:0]  ptr_o
);
    // Pointer register with range guard.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_o <= '0;
        else if (wr_i && (wdata_i < DATA_W'(NUM_REGS)))
            ptr_o <= wdata_i[PTR_W-1:0];
    end
endmodule

// File: rtl/netctl_aux.sv
// Module: plain storage for registers 1..NUM_REGS-1. Slot 0 is tied to
// zero because the control word lives elsewhere. Assumes the pointer is
// already range-checked.
module netctl_aux #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 4,
    localparam int PTR_W   = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_i,
    input  logic [PTR_W-1:0]                 ptr_i,
    input  logic [DATA_W-1:0]                wdata_i,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
    assign regs_o[0] = '0;

    for (genvar g = 1; g < NUM_REGS; g++) begin : g_slot
        // Store one register when selected by the pointer.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_o[g] <= '0;
            else if (wr_i && (ptr_i == PTR_W'(g)))
                regs_o[g] <= wdata_i;
        end
    end
endmodule

// File: rtl/netctl_ctrl.sv
// Module: control word. Applies the bit classes in a fixed order:
// stop override, host clear, engine set, summary recompute, enable,
// commands. Assumes strobes are single-cycle pulses.
module netctl_ctrl
    import netctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic [6:0]  clr_i,
    input  logic        ien_i,
    input  logic        init_i,
    input  logic        start_i,
    input  logic        stop_i,
    input  logic        rx_set_i,
    input  logic        tx_set_i,
    output logic [15:0] cw_o
);
    logic [15:0] cw_nxt;

    // Next-state computation in the documented precedence order.
    always_comb begin
        cw_nxt = cw_o;
        if (wr_i && stop_i) begin
            cw_nxt = CW_RESET;
        end else begin
            if (wr_i)
                cw_nxt[CW_CLR_HI:CW_CLR_LO] = cw_nxt[CW_CLR_HI:CW_CLR_LO] & ~clr_i;
            if (rx_set_i) cw_nxt[CW_RINT] = 1'b1;
            if (tx_set_i) cw_nxt[CW_TINT] = 1'b1;
            if (wr_i) begin
                cw_nxt[CW_ERR]  = cw_nxt[14] | cw_nxt[13] | cw_nxt[12] | cw_nxt[CW_IDON];
                cw_nxt[CW_INTR] = |cw_nxt[CW_CLR_HI:CW_CLR_LO];
                cw_nxt[CW_IEN]  = ien_i;
                if (init_i) begin
                    cw_nxt[CW_INIT] = 1'b1;
                    cw_nxt[CW_IDON] = 1'b1;
                    cw_nxt[CW_STOP] = 1'b0;
                end else if (start_i) begin
                    cw_nxt[CW_START] = 1'b1;
                    cw_nxt[CW_RXON]  = 1'b1;
                    cw_nxt[CW_TXON]  = 1'b1;
                    cw_nxt[CW_STOP]  = 1'b0;
                end
            end else if (rx_set_i || tx_set_i) begin
                cw_nxt[CW_INTR] = 1'b1;
            end
        end
    end

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n) cw_o <= CW_RESET;
        else        cw_o <= cw_nxt;
    end
endmodule

// File: rtl/netctl_regif.sv
// Module: top of the host register interface. Decodes the two word
// ports, muxes read data, forms the 32-bit init address and the
// interrupt. Assumes NUM_REGS >= 3 so both address halves exist.
module netctl_regif
    import netctl_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 4,
    localparam int PTR_W   = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic                host_sel,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic [DATA_W-1:0]   host_rdata,
    input  logic                rx_done,
    input  logic                tx_done,
    output logic [2*DATA_W-1:0] init_ptr,
    output logic                irq
);
    logic [PTR_W-1:0]                ptr_q;
    logic [15:0]                     csr0_q;
    logic [NUM_REGS-1:0][DATA_W-1:0] aux_q;
    logic                            ptr_wr, data_wr, cw_wr;

    // Port decode.
    assign ptr_wr  = host_wr &&  host_sel;
    assign data_wr = host_wr && !host_sel;
    assign cw_wr   = data_wr && (ptr_q == PTR_W'(REG_CTRL));

    netctl_ptr #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) i_ptr (
        .clk(clk), .rst_n(rst_n), .wr_i(ptr_wr),
        .wdata_i(host_wdata), .ptr_o(ptr_q)
    );

    netctl_aux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) i_aux (
        .clk(clk), .rst_n(rst_n), .wr_i(data_wr), .ptr_i(ptr_q),
        .wdata_i(host_wdata), .regs_o(aux_q)
    );

    netctl_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_i(cw_wr),
        .clr_i(host_wdata[CW_CLR_HI:CW_CLR_LO]),
        .ien_i(host_wdata[CW_IEN]), .init_i(host_wdata[CW_INIT]),
        .start_i(host_wdata[CW_START]), .stop_i(host_wdata[CW_STOP]),
        .rx_set_i(rx_done), .tx_set_i(tx_done), .cw_o(csr0_q)
    );

    // Read mux of the selected port.
    always_comb begin
        if (host_sel)
            host_rdata = DATA_W'(ptr_q);
        else if (ptr_q == PTR_W'(REG_CTRL))
            host_rdata = DATA_W'(csr0_q);
        else
            host_rdata = aux_q[ptr_q];
    end

    assign init_ptr = {aux_q[REG_ADRHI], aux_q[REG_ADRLO]};
    assign irq      = csr0_q[CW_INTR] & csr0_q[CW_IEN];
endmodule

// File: rtl/netctl_regif_chk.sv
// Module: property checker for netctl_regif, attached by bind.
module netctl_regif_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic        host_sel,
    input logic [15:0] host_wdata,
    input logic        rx_done,
    input logic        tx_done,
    input logic [31:0] init_ptr,
    input logic        irq,
    input logic [1:0]  ptr_q,
    input logic [15:0] csr0_q
);
    // R2
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel && host_wdata >= 16'd4) |=> $stable(ptr_q));
    // R4
    stop_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_sel && ptr_q == 2'd0 && host_wdata[2]) |=> csr0_q == 16'h0004);
    // R9
    adr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_sel && ptr_q == 2'd1) |=> init_ptr[15:0] == $past(host_wdata));
    // R10
    rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !(host_wr && !host_sel && ptr_q == 2'd0 && host_wdata[2]))
        |=> (csr0_q[10] && csr0_q[7]));
    // R11
    irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> csr0_q[6]);
    // R12
    spare_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_sel && ptr_q == 2'd3 && !rx_done && !tx_done) |=> $stable(csr0_q));
endmodule

bind netctl_regif netctl_regif_chk i_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .rx_done(rx_done), .tx_done(tx_done),
    .init_ptr(init_ptr), .irq(irq), .ptr_q(ptr_q), .csr0_q(csr0_q)
);

// File: tb/test_netctl_regif.sv
// Bench: table-driven walk of the control word, then directed cases.
module test_netctl_regif;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_sel = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        rx_done = 1'b0;
    logic        tx_done = 1'b0;
    logic [31:0] init_ptr;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    netctl_regif i_netctl_regif (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rx_done(rx_done), .tx_done(tx_done), .init_ptr(init_ptr), .irq(irq)
    );

    // {wr, wdata, rx, tx, expected control word, expected irq}
    localparam logic [35:0] VEC [8] = '{
        {1'b1, 16'h0002, 1'b0, 1'b0, 16'h0032, 1'b0},
        {1'b1, 16'h0041, 1'b0, 1'b0, 16'h0173, 1'b0},
        {1'b1, 16'h0040, 1'b0, 1'b0, 16'h81F3, 1'b1},
        {1'b1, 16'h0140, 1'b1, 1'b0, 16'h04F3, 1'b1},
        {1'b1, 16'h0400, 1'b0, 1'b0, 16'h0033, 1'b0},
        {1'b0, 16'h0000, 1'b0, 1'b1, 16'h02B3, 1'b0},
        {1'b1, 16'h0240, 1'b0, 1'b1, 16'h02F3, 1'b1},
        {1'b1, 16'h0204, 1'b1, 1'b0, 16'h0004, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic sel, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic sel, output logic [15:0] d);
        @(negedge clk);
        host_sel = sel;
        #1 d = host_rdata;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin : main
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        hread(1'b0, rd); check("R1 control word", 32'(rd), 32'h0004);
        hread(1'b1, rd); check("R1 pointer", 32'(rd), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 init_ptr", init_ptr, 32'h0);

        // Table walk: R4 R5 R6 R7 R8 R10 R11
        host_sel = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            host_wr = VEC[i][35]; host_sel = 1'b0; host_wdata = VEC[i][34:19];
            rx_done = VEC[i][18]; tx_done = VEC[i][17];
            @(negedge clk);
            host_wr = 1'b0; rx_done = 1'b0; tx_done = 1'b0;
            #1;
            check($sformatf("R5/R6/R8/R10 vector %0d word", i), 32'(host_rdata), 32'(VEC[i][16:1]));
            check($sformatf("R7/R11 vector %0d irq", i), 32'(irq), 32'(VEC[i][0]));
        end

        // R2 pointer range
        hwrite(1'b1, 16'd2);
        hread(1'b1, rd); check("R2 pointer load", 32'(rd), 32'd2);
        hwrite(1'b1, 16'd4);
        hread(1'b1, rd); check("R2 pointer limit 4 ignored", 32'(rd), 32'd2);
        hwrite(1'b1, 16'hFFFF);
        hread(1'b1, rd); check("R2 pointer large ignored", 32'(rd), 32'd2);

        // R9 address halves, R3 window
        hwrite(1'b0, 16'h1234);
        hwrite(1'b1, 16'd1);
        hwrite(1'b0, 16'hABCD);
        check("R9 init_ptr", init_ptr, 32'h1234ABCD);
        hread(1'b0, rd); check("R3 R9 register 1 readback", 32'(rd), 32'hABCD);
        hwrite(1'b1, 16'd2);
        hread(1'b0, rd); check("R9 register 2 readback", 32'(rd), 32'h1234);

        // R12 spare register
        hwrite(1'b1, 16'd3);
        hwrite(1'b0, 16'hFFC7);
        hread(1'b0, rd); check("R12 register 3 readback", 32'(rd), 32'hFFC7);
        check("R12 irq unchanged", 32'(irq), 32'h0);
        hwrite(1'b1, 16'd0);
        hread(1'b0, rd); check("R3 R12 control word untouched", 32'(rd), 32'h0004);

        // R8 init beats start
        hwrite(1'b0, 16'h0003);
        hread(1'b0, rd); check("R8 init priority", 32'(rd), 32'h0101);

        // R1 reset mid-run
        hwrite(1'b1, 16'd2);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        hread(1'b1, rd); check("R1 pointer after reset", 32'(rd), 32'h0);
        hread(1'b0, rd); check("R1 control word after reset", 32'(rd), 32'h0004);
        check("R1 init_ptr after reset", init_ptr, 32'h0);

        done = 1'b1;
        finish_run();
    end
endmodule